// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-facing register set of a legacy byte-wide printer port. A host reaches it over a single-cycle register bus: a request is presented with `req_valid`, writes take effect at the clock edge, and read data is returned combinationally in the same cycle. The block holds an output data latch, an input data latch, a status byte and a control byte.

Instead of timing physical pins, the block runs a simplified printer handshake. When software raises the strobe bit in the control register, the output latch is sent as one byte on a valid/ready stream. The busy and acknowledge status bits then step forward each time the host polls status. A level interrupt is raised when software drops strobe while interrupts are enabled. The interrupt is cleared by the next status read.

The output stream holds one byte. `out_valid` stays high, with `out_data` stable, until the consumer asserts `out_ready`. The block cannot stall the host. If a new byte is sent while the held byte is still waiting (`out_valid` high and `out_ready` low), the new byte is discarded and the sticky `out_ovf` flag is set. If `out_ready` is high in the same cycle, the slot frees and the new byte is taken.

Top module: `prn_port_regs`

## Requirements
- R1: After reset the output latch and input latch are 0xFF, status is 0xD9, control is 0xCC, and `irq_o`, `out_valid` and `out_ovf` are 0.
- R2: Only address bits 2:0 are decoded: 0 selects data, 1 selects status and 2 selects control. Reads at offsets 3 to 7 return 0xFF. Writes to offset 1 or to offsets 3 to 7 change no state.
- R3: A control write stores the written byte with bits 7:6 forced to 1, and a control read returns the stored value.
- R4: A control write whose init bit (bit 2) is 0 loads status with 0xD8.
- R5: A control write with init=1, select-in (bit 3)=1 and strobe (bit 0)=1 clears status bit 7 (inverted busy). If the previously stored strobe bit was 0, the output latch is sent as one stream byte.
- R6: A control write with init=1, select-in=1 and strobe=0 sets interrupt pending if the interrupt-enable bit (bit 4) of the previously stored control value is 1.
- R7: A status read returns the current status and clears interrupt pending. If bit 7 was 0 and the stored strobe bit is 0, it then steps: when bit 6 (ack) is 1, bit 6 is cleared; otherwise bits 7 and 6 are both set.
- R8: A data read returns the input latch when control bit 5 (direction) is 1, and the output latch otherwise.
- R9: While direction is 1, the input latch samples `port_din` on every clock edge. While direction is 0, the input latch holds its value. The first data read after direction becomes 1 therefore still returns the old latch value.
- R10: `irq_o` is a registered copy of interrupt pending and lags it by one clock cycle.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable.
- R12: A byte sent while `out_valid` is high and `out_ready` is low is dropped and sets `out_ovf`. `out_ovf` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address (low 3 bits decoded) |
| req_wdata | input | 8 | Write data |
| req_rdata | output | 8 | Read data, valid in the request cycle |
| port_din | input | 8 | Input byte from the port |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Output byte |
| out_ovf | output | 1 | Sticky flag: an output byte was dropped |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps every control byte value, each one preceded by a fresh data byte and followed by a status poll. A reference model predicts status, interrupt and stream behaviour. The following faults would show up:
- A design that compares the new strobe bit instead of the previous one would send bytes on every strobe-high write, so the stream would receive extra bytes.
- A design that tests interrupt enable in the new control value would raise spurious interrupts.
- A design that evaluates the busy/ack step before the read result is formed would return already-advanced status values.

Directed cases cover the following:
- the one-cycle lag of the input latch after a direction change;
- aliasing through the upper address bits;
- writes to the status offset being ignored;
- the drop-and-flag path when a second byte arrives while the consumer stalls.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;

  localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd2;

  // status bit positions
  localparam int ST_NBUSY = 7;
  localparam int ST_ACK   = 6;

  // control bit positions
  localparam int CT_DIR   = 5;
  localparam int CT_IRQEN = 4;
  localparam int CT_SEL   = 3;
  localparam int CT_INIT  = 2;
  localparam int CT_STB   = 0;

  localparam logic [BYTE_W-1:0] RST_STATUS  = 8'hD9;
  localparam logic [BYTE_W-1:0] INIT_STATUS = 8'hD8;
  localparam logic [BYTE_W-1:0] RST_CTRL    = 8'hCC;
  localparam logic [BYTE_W-1:0] CTRL_FORCE  = 8'hC0;
  localparam logic [BYTE_W-1:0] IDLE_BYTE   = 8'hFF;
endpackage

// File: rtl/prn_status_seq.sv
module prn_status_seq
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_init,
  input  logic              clr_busy,
  input  logic              rd_stat,
  input  logic              ctrl_stb,
  output logic [BYTE_W-1:0] status
);
  logic step;

  // poll-driven handshake advance: only when busy shows and strobe is low
  assign step = rd_stat && !status[ST_NBUSY] && !ctrl_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= RST_STATUS;
    end else if (ld_init) begin
      status <= INIT_STATUS;
    end else if (clr_busy) begin
      status[ST_NBUSY] <= 1'b0;
    end else if (step) begin
      if (status[ST_ACK]) begin
        status[ST_ACK] <= 1'b0;
      end else begin
        status[ST_ACK]   <= 1'b1;
        status[ST_NBUSY] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prn_out_slot.sv
module prn_out_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_ovf
);
  logic busy_slot;

  // slot is occupied for this cycle only if the consumer does not take it now
  assign busy_slot = out_valid && !out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (push) begin
        if (busy_slot) begin
          out_ovf <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_data  <= push_data;
        end
      end
    end
  end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic [BYTE_W-1:0] req_rdata,
  input  logic [BYTE_W-1:0] port_din,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_ovf,
  output logic              irq_o
);
  logic [OFF_W-1:0]  sel;
  logic              wr_data, wr_ctrl, rd_stat;
  logic [BYTE_W-1:0] ctrl_new;
  logic              armed, ld_init, clr_busy, emit, set_pend;
  logic [BYTE_W-1:0] out_lat, in_lat, ctrl_q, status;
  logic              pend_q;

  assign sel     = req_addr[OFF_W-1:0];
  assign wr_data = req_valid && req_write  && (sel == OFF_DATA);
  assign wr_ctrl = req_valid && req_write  && (sel == OFF_CTRL);
  assign rd_stat = req_valid && !req_write && (sel == OFF_STAT);

  assign ctrl_new = req_wdata | CTRL_FORCE;
  assign ld_init  = wr_ctrl && !ctrl_new[CT_INIT];
  assign armed    = wr_ctrl &&  ctrl_new[CT_INIT] && ctrl_new[CT_SEL];
  assign clr_busy = armed &&  ctrl_new[CT_STB];
  assign emit     = clr_busy && !ctrl_q[CT_STB];
  assign set_pend = armed && !ctrl_new[CT_STB] && ctrl_q[CT_IRQEN];

  prn_status_seq u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_init  (ld_init),
    .clr_busy (clr_busy),
    .rd_stat  (rd_stat),
    .ctrl_stb (ctrl_q[CT_STB]),
    .status   (status)
  );

  prn_out_slot #(.W(BYTE_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (emit),
    .push_data (out_lat),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_ovf   (out_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_lat <= IDLE_BYTE;
      in_lat  <= IDLE_BYTE;
      ctrl_q  <= RST_CTRL;
      pend_q  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (wr_data) out_lat <= req_wdata;
      if (ctrl_q[CT_DIR]) in_lat <= port_din;
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (rd_stat)       pend_q <= 1'b0;
      else if (set_pend) pend_q <= 1'b1;
      irq_o <= pend_q;
    end
  end

  always_comb begin
    unique case (sel)
      OFF_DATA: req_rdata = ctrl_q[CT_DIR] ? in_lat : out_lat;
      OFF_STAT: req_rdata = status;
      OFF_CTRL: req_rdata = ctrl_q;
      default:  req_rdata = IDLE_BYTE;
    endcase
  end
endmodule

// File: rtl/prn_port_regs_chk.sv
module prn_port_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_wdata,
  input logic [7:0]        req_rdata,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_ovf,
  input logic              irq_o
);
  // R2
  unmapped_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[2:0] > 3'd2) |-> req_rdata == 8'hFF);

  // R3
  ctrl_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[2:0] == 3'd2) |-> req_rdata[7:6] == 2'b11);

  // R5
  emit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(req_valid && req_write && req_addr[2:0] == 3'd2 && req_wdata[0]));

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[2:0] == 3'd1) |=> ##1 !irq_o);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |=> out_ovf);
endmodule

bind prn_port_regs prn_port_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .req_rdata (req_rdata),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_ovf   (out_ovf),
  .irq_o     (irq_o)
);

// File: tb/prn_port_regs_tb_top.sv
`timescale 1ns/1ps
module prn_port_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = 8'h00, req_wdata = 8'h00, req_rdata, port_din = 8'h00;
  logic out_valid, out_ready = 1'b1, out_ovf, irq_o;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  logic [7:0] m_st, m_ctrl, m_out;
  logic m_pend;
  logic drop_next = 1'b0;
  logic [7:0] exp_q [0:1023];
  int wr_idx = 0, rd_idx = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prn_port_regs #(.ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .port_din(port_din), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ovf(out_ovf), .irq_o(irq_o));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // stream monitor (R5, R11): compare every accepted byte with the expected order
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (rd_idx < wr_idx) chk(out_data, exp_q[rd_idx], "R5 stream byte");
      else chk(8'h01, 8'h00, "R5 unexpected stream byte");
      rd_idx++;
    end
  end

  task automatic acc(input logic w, input logic [7:0] a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1 q = req_rdata;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] q;
    acc(1'b1, a, d, q);
  endtask

  task automatic wr_data(input logic [7:0] d);
    wr(8'h00, d);
    m_out = d;
  endtask

  // reference model of a control write (R3..R6)
  task automatic wr_ctrl(input logic [7:0] d);
    logic [7:0] v;
    v = d | 8'hC0;
    wr(8'h02, d);
    if (!v[2]) m_st = 8'hD8;
    else if (v[3]) begin
      if (v[0]) begin
        m_st[7] = 1'b0;
        if (!m_ctrl[0]) begin
          if (drop_next) drop_next = 1'b0;
          else begin exp_q[wr_idx] = m_out; wr_idx++; end
        end
      end else if (m_ctrl[4]) m_pend = 1'b1;
    end
    m_ctrl = v;
  endtask

  // reference model of a status read (R7)
  task automatic rd_stat(input string tag);
    logic [7:0] q;
    acc(1'b0, 8'h01, 8'h00, q);
    chk(q, m_st, tag);
    m_pend = 1'b0;
    if (!m_st[7] && !m_ctrl[0]) begin
      if (m_st[6]) m_st[6] = 1'b0;
      else m_st[7:6] = 2'b11;
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] q;
    acc(1'b0, a, 8'h00, q);
    chk(q, exp, tag);
  endtask

  task automatic chk_irq(input string tag);
    @(posedge clk); #1;
    chk({7'd0, irq_o}, {7'd0, m_pend}, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_st = 8'hD9; m_ctrl = 8'hCC; m_out = 8'hFF; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk({5'd0, out_valid, out_ovf, irq_o}, 8'h00, "R1 flags after reset");
    rd_chk(8'h00, 8'hFF, "R1 output latch reset");
    rd_chk(8'h02, 8'hCC, "R1 control reset");
    rd_stat("R1 status reset");

    // R2 decode
    for (int a = 3; a < 8; a++) rd_chk(8'(a), 8'hFF, "R2 unmapped read");
    wr(8'h01, 8'h00);
    rd_stat("R2 status write ignored");
    wr(8'h05, 8'h00); wr(8'h07, 8'h12);
    rd_chk(8'h00, 8'hFF, "R2 data after unmapped write");
    rd_chk(8'h02, 8'hCC, "R2 control after unmapped write");
    rd_chk(8'hA2, 8'hCC, "R2 upper address bits ignored");

    // R8, R9 direction and input latch
    port_din = 8'h3C;
    wr_ctrl(8'h2C);
    rd_chk(8'h00, 8'hFF, "R9 input latch lags one cycle");
    rd_chk(8'h00, 8'h3C, "R8 read input latch");
    port_din = 8'h81;
    rd_chk(8'h00, 8'h3C, "R9 latch one cycle old");
    rd_chk(8'h00, 8'h81, "R9 latch follows input");
    wr_ctrl(8'h0C);
    port_din = 8'h55;
    rd_chk(8'h00, 8'hFF, "R8 read output latch");

    // R5, R7 handshake walk
    wr_data(8'hA5);
    wr_ctrl(8'h0D);
    rd_stat("R5 busy cleared");
    chk(m_st, 8'h59, "R5 model busy value");
    wr_ctrl(8'h0C);
    rd_stat("R7 first poll");
    rd_stat("R7 ack cleared");
    rd_stat("R7 busy and ack set");
    chk(m_st, 8'hD9, "R7 sequence returns idle");
    // R6 interrupt with enable held before the strobe-low write
    wr_ctrl(8'h1C);
    chk_irq("R10 no irq when enable only now set");
    wr_ctrl(8'h1C);
    chk_irq("R6 irq raised");
    rd_stat("R6 status with irq");
    chk_irq("R10 irq cleared by status read");
    // R4 init
    wr_ctrl(8'h08);
    rd_stat("R4 init loads status");

    // sweep every control byte
    for (int v = 0; v < 256; v++) begin
      wr_data(8'(v) ^ 8'h5A);
      wr_ctrl(8'(v));
      chk_irq("R6 sweep irq after control write");
      rd_chk(8'h02, 8'(v) | 8'hC0, "R3 control readback");
      rd_stat("R7 sweep status read");
      chk_irq("R10 sweep irq after status read");
    end
    repeat (4) @(negedge clk);
    chk(8'(rd_idx), 8'(wr_idx), "R5 stream byte count");

    // R11, R12 back-pressure and overflow
    wr_ctrl(8'h0C);
    out_ready = 1'b0;
    wr_data(8'h11);
    wr_ctrl(8'h0D);
    wr_ctrl(8'h0C);
    wr_data(8'h22);
    drop_next = 1'b1;
    wr_ctrl(8'h0D);
    repeat (3) @(negedge clk);
    #1;
    chk({7'd0, out_valid}, 8'h01, "R11 valid held");
    chk(out_data, 8'h11, "R11 data held");
    chk({7'd0, out_ovf}, 8'h01, "R12 overflow set");
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    chk({7'd0, out_valid}, 8'h00, "R11 valid drops after accept");
    chk({7'd0, out_ovf}, 8'h01, "R12 overflow sticky");
    chk(8'(rd_idx), 8'(wr_idx), "R12 dropped byte not sent");
    // ready in the same cycle as a new byte: no drop
    wr_ctrl(8'h0C);
    wr_data(8'h33);
    wr_ctrl(8'h0D);
    repeat (3) @(negedge clk);
    #3;
    chk(8'(rd_idx), 8'(wr_idx), "R12 byte taken when ready");

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule